// File: doc/BRIEF.md
# Supply Brown-out Supervisor

This block is the digital side of a supply-voltage monitor in a small microcontroller. An analog comparator outside the block drives an active-high "supply is low" line. The block passes that line through a two-flop synchroniser. It then counts how long the line stays high without a break. Once the line has been high for at least 100 ns, the block treats it as a genuine brown-out and not as noise.

A single byte-wide control/status register sits on a simple register bus. It holds a mode bit, a detection-disable bit and a sticky status bit. A qualified brown-out always sets the status bit while detection is enabled. Depending on the mode bit, it also issues a system reset request of fixed length. The reset request does not touch the status bit, so software can see after restart why the reset happened. When the mode bit is clear, the core keeps running and software polls the status bit or watches the status output.

Top module: `pwrfail_supervisor`

## Requirements
- R1: While `rst` is high and after it, until the first write, the register reads 0x04: mode bit (bit 2) = 1, disable bit (bit 1) = 0, status bit (bit 0) = 0. `sys_rst_req_o` and `fail_status_o` are 0 at that time.
- R2: The register answers only at byte address 0xEF. Its bits 7 to 3 always read 0. Any other address reads 0x00, and writes to any other address change nothing.
- R3: A brown-out qualifies only when the synchronised supply-low input stays high for at least FILT_CYCLES consecutive clocks. With the default 5 ns clock and 100 ns minimum, FILT_CYCLES = 20. A shorter stretch, or two stretches split by a single low cycle, does not qualify.
- R4: Counting the first rising edge that samples the raw input high as edge 1, the status bit and any reset request become visible after edge FILT_CYCLES+3. Read data is registered: it shows the register state from the edge at which the address is presented.
- R5: While the disable bit is 1, a brown-out sets no status and requests no reset.
- R6: With the mode bit at 1 and detection enabled, a qualified brown-out drives `sys_rst_req_o` high for exactly RST_PULSE_CYCLES clocks (default 8). With the mode bit at 0, no reset is requested and only the status bit records the event.
- R7: The status bit stays 1 until software writes 0 to bit 0 at 0xEF. Writing 1 to bit 0 leaves it unchanged.
- R8: If a clearing write and a qualified brown-out land on the same clock edge, the status bit ends up 1.
- R9: The reset request does not clear the status bit.
- R10: An unbroken low-supply stretch produces exactly one event, however long it lasts.
- R11: `fail_status_o` always equals the status bit that the register reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_low_i | input | 1 | Raw asynchronous supply-below-threshold flag from the comparator |
| bus_addr_i | input | ADDR_W (8) | Register bus byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data for the address presented on the previous edge |
| sys_rst_req_o | output | 1 | System reset request pulse |
| fail_status_o | output | 1 | Copy of the sticky status bit |

## Verification
Each result has a fixed delay from its stimulus. A raw input held high across edges 1..FILT_CYCLES gives status and reset after edge FILT_CYCLES+3: two synchroniser flops, the counter, the event flop and the status/pulse flop. Read data arrives one edge after the address, and a write takes effect on the edge it is presented at. The bench samples 1 ns after each rising edge. At the latency boundary it checks both the edge before the expected change and the edge of the change. For long stimulus vectors it counts reset-request cycles over the whole window, so it can check the pulse width and its uniqueness exactly.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;
  localparam int CTL_W    = 8;
  localparam int MODE_BIT = 2;
  localparam int DIS_BIT  = 1;
  localparam int STAT_BIT = 0;

  typedef struct packed {
    logic mode;
    logic dis;
    logic status;
  } pf_ctl_t;

  localparam pf_ctl_t CTL_RESET = '{mode: 1'b1, dis: 1'b0, status: 1'b0};

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pf_filter.sv
module pf_filter #(
  parameter int FILT_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic event_o
);
  localparam int CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FILT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(FILT_CYCLES - 1);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      event_o <= 1'b0;
    end else begin
      if (!level_i)
        run_cnt <= '0;
      else if (run_cnt != CNT_MAX)
        run_cnt <= run_cnt + 1'b1;
      event_o <= level_i && (run_cnt == CNT_FIRE);
    end
  end
endmodule

// File: rtl/pf_regs.sv
module pf_regs
  import pwrfail_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [CTL_W-1:0]  wdata_i,
  input  logic              event_i,
  output pf_ctl_t           ctl_o,
  output logic              trig_o,
  output logic [CTL_W-1:0]  rdata_o
);
  pf_ctl_t ctl_q;
  logic    hit;
  logic    accept;

  assign hit    = (addr_i == REG_ADDR);
  assign accept = event_i && !ctl_q.dis;
  assign trig_o = accept && ctl_q.mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RESET;
    end else begin
      if (wr_i && hit) begin
        ctl_q.mode <= wdata_i[MODE_BIT];
        ctl_q.dis  <= wdata_i[DIS_BIT];
      end
      if (accept)
        ctl_q.status <= 1'b1;
      else if (wr_i && hit && !wdata_i[STAT_BIT])
        ctl_q.status <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= '0;
      if (hit) begin
        rdata_o[MODE_BIT] <= ctl_q.mode;
        rdata_o[DIS_BIT]  <= ctl_q.dis;
        rdata_o[STAT_BIT] <= ctl_q.status;
      end
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/pf_pulse.sv
module pf_pulse #(
  parameter int PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_o <= 1'b0;
    end else if (trig_i) begin
      left_q  <= CNT_LOAD;
      pulse_o <= 1'b1;
    end else if (left_q != '0) begin
      left_q  <= left_q - 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwrfail_supervisor.sv
module pwrfail_supervisor
  import pwrfail_pkg::*;
#(
  parameter int                ADDR_W           = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR         = 8'hEF,
  parameter int                CLK_PERIOD_PS    = 5000,
  parameter int                MIN_FAIL_PS      = 100000,
  parameter int                SYNC_STAGES      = 2,
  parameter int                RST_PULSE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_low_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              sys_rst_req_o,
  output logic              fail_status_o
);
  localparam int FILT_CYCLES = ceil_div(MIN_FAIL_PS, CLK_PERIOD_PS);

  logic    sync_q;
  logic    evt;
  logic    trig;
  pf_ctl_t ctl;
  logic    cfg_mode;
  logic    cfg_dis;
  logic    cfg_status;

  pf_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i (supply_low_i),
    .q_o (sync_q)
  );

  pf_filter #(.FILT_CYCLES(FILT_CYCLES)) i_filter (
    .clk     (clk),
    .rst     (rst),
    .level_i (sync_q),
    .event_o (evt)
  );

  pf_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .wdata_i (bus_wdata_i),
    .event_i (evt),
    .ctl_o   (ctl),
    .trig_o  (trig),
    .rdata_o (bus_rdata_o)
  );

  pf_pulse #(.PULSE_CYCLES(RST_PULSE_CYCLES)) i_pulse (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig),
    .pulse_o (sys_rst_req_o)
  );

  assign cfg_mode      = ctl.mode;
  assign cfg_dis       = ctl.dis;
  assign cfg_status    = ctl.status;
  assign fail_status_o = ctl.status;
endmodule

// File: rtl/pwrfail_supervisor_chk.sv
module pwrfail_supervisor_chk #(
  parameter int                ADDR_W           = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR         = 8'hEF,
  parameter int                RST_PULSE_CYCLES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [7:0]        bus_wdata_i,
  input logic [7:0]        bus_rdata_o,
  input logic              sys_rst_req_o,
  input logic              sync_q,
  input logic              evt,
  input logic              cfg_mode,
  input logic              cfg_dis,
  input logic              cfg_status
);
  logic [15:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst || !sys_rst_req_o) hi_run <= '0;
    else if (hi_run != 16'hFFFF) hi_run <= hi_run + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_mode && !cfg_dis && !cfg_status && !sys_rst_req_o));

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata_o[7:3] == 5'd0);

  assert_event_needs_level_R3: assert property (@(posedge clk) disable iff (rst)
    evt |-> $past(sync_q));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_dis && !cfg_status) |=> !cfg_status);

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req_o) |-> ($past(cfg_mode) && !$past(cfg_dis) && cfg_status));

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (rst)
    hi_run <= 16'(RST_PULSE_CYCLES));

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_status && !(bus_wr_i && bus_addr_i == REG_ADDR && !bus_wdata_i[0])) |=> cfg_status);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (evt && !cfg_dis) |=> cfg_status);
endmodule

bind pwrfail_supervisor pwrfail_supervisor_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RST_PULSE_CYCLES(RST_PULSE_CYCLES)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_addr_i    (bus_addr_i),
  .bus_wr_i      (bus_wr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .sys_rst_req_o (sys_rst_req_o),
  .sync_q        (sync_q),
  .evt           (evt),
  .cfg_mode      (cfg_mode),
  .cfg_dis       (cfg_dis),
  .cfg_status    (cfg_status)
);

// File: tb/test_pwrfail_supervisor.sv
`timescale 1ns/1ps
module test_pwrfail_supervisor;
  localparam int FILT  = 20;   // 100 ns / 5 ns
  localparam int PULSE = 8;
  localparam logic [7:0] REG = 8'hEF;

  // {len[7:0], mode, dis, exp_status, exp_pulse[3:0]}
  localparam int NVEC = 8;
  localparam logic [14:0] VEC [NVEC] = '{
    {8'd20, 1'b1, 1'b0, 1'b1, 4'd8},   // R3 exact length, R6 reset pulse
    {8'd19, 1'b1, 1'b0, 1'b0, 4'd0},   // R3 one short
    {8'd60, 1'b0, 1'b0, 1'b1, 4'd0},   // R6 status only
    {8'd20, 1'b0, 1'b1, 1'b0, 4'd0},   // R5 disabled
    {8'd60, 1'b1, 1'b1, 1'b0, 4'd0},   // R5 disabled in reset mode
    {8'd1,  1'b0, 1'b0, 1'b0, 4'd0},   // R3 glitch
    {8'd45, 1'b1, 1'b0, 1'b1, 4'd8},   // R10 single event
    {8'd21, 1'b0, 1'b0, 1'b1, 4'd0}    // R3 over length
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_low_i = 1'b0;
  logic [7:0] bus_addr_i = 8'h00;
  logic       bus_wr_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       sys_rst_req_o;
  logic       fail_status_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwrfail_supervisor i_pwrfail_supervisor (
    .clk           (clk),
    .rst           (rst),
    .supply_low_i  (supply_low_i),
    .bus_addr_i    (bus_addr_i),
    .bus_wr_i      (bus_wr_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_rdata_o   (bus_rdata_o),
    .sys_rst_req_o (sys_rst_req_o),
    .fail_status_o (fail_status_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wr_i = 1'b0;
    @(posedge clk);
    #1 d = bus_rdata_o;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #750000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] rd;
    int pcnt;
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset req", sys_rst_req_o, 0);
    check("R1 reset status out", fail_status_o, 0);
    @(negedge clk); rst = 1'b0;
    bus_read(REG, rd);
    check("R1 reset value", rd, 8'h04);

    // R2 decoding
    bus_read(8'h10, rd);
    check("R2 other address reads zero", rd, 0);
    bus_write(8'h10, 8'hFF);
    bus_read(REG, rd);
    check("R2 foreign write ignored", rd, 8'h04);
    bus_write(REG, 8'hFF);
    bus_read(REG, rd);
    check("R2 upper bits zero, R7 write 1 no effect", rd, 8'h06);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      int len;
      len = int'(VEC[v][14:7]);
      bus_write(REG, {5'd0, VEC[v][6], VEC[v][5], 1'b0});
      pcnt = 0;
      @(negedge clk); supply_low_i = 1'b1;
      for (int i = 0; i < len; i++) begin
        @(posedge clk); #1 if (sys_rst_req_o) pcnt++;
        @(negedge clk);
      end
      supply_low_i = 1'b0;
      for (int i = 0; i < 60; i++) begin
        @(posedge clk); #1 if (sys_rst_req_o) pcnt++;
      end
      bus_read(REG, rd);
      check($sformatf("R3/R5/R6 vec%0d status", v), rd[0], VEC[v][4]);
      check($sformatf("R6/R10 vec%0d pulse cycles", v), pcnt, int'(VEC[v][3:0]));
      check($sformatf("R11 vec%0d status pin", v), fail_status_o, rd[0]);
      if (VEC[v][3:0] != 0)
        check($sformatf("R9 vec%0d status kept after pulse", v), rd[0], 1);
    end

    // R3 break restarts the count
    bus_write(REG, 8'h00);
    @(negedge clk); supply_low_i = 1'b1;
    repeat (15) @(negedge clk);
    supply_low_i = 1'b0;
    @(negedge clk); supply_low_i = 1'b1;
    repeat (15) @(negedge clk);
    supply_low_i = 1'b0;
    repeat (40) @(negedge clk);
    bus_read(REG, rd);
    check("R3 split stretch no event", rd[0], 0);

    // R4 exact latency, reset mode
    bus_write(REG, 8'h04);
    @(negedge clk); supply_low_i = 1'b1;
    for (int i = 1; i <= FILT + 3; i++) begin
      @(posedge clk); #1;
      if (i == FILT + 2) begin
        check("R4 status not before edge F+3", fail_status_o, 0);
        check("R4 req not before edge F+3", sys_rst_req_o, 0);
      end
      if (i == FILT + 3) begin
        check("R4 status at edge F+3", fail_status_o, 1);
        check("R4 req at edge F+3", sys_rst_req_o, 1);
      end
    end
    @(negedge clk); supply_low_i = 1'b0;
    repeat (20) @(negedge clk);

    // R8 set beats clear on the same edge
    bus_write(REG, 8'h00);
    check("R8 precondition cleared", fail_status_o, 0);
    @(negedge clk); supply_low_i = 1'b1;
    repeat (FILT + 2) @(negedge clk);
    bus_addr_i = REG; bus_wdata_i = 8'h00; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
    supply_low_i = 1'b0;
    #1 check("R8 set wins over clear", fail_status_o, 1);

    // R7 sticky and clear
    repeat (50) @(negedge clk);
    check("R7 status holds", fail_status_o, 1);
    bus_write(REG, 8'h01);
    bus_read(REG, rd);
    check("R7 write 1 keeps status", rd[0], 1);
    bus_write(REG, 8'h00);
    bus_read(REG, rd);
    check("R7 write 0 clears status", rd[0], 0);
    check("R11 pin follows clear", fail_status_o, 0);

    done = 1'b1;
    finish_run();
  end
endmodule